// File: doc/BRIEF.md
# Shared SPI Pin Arbiter

This block sits between an internal serial-EEPROM engine and the four pins of an attached SPI EEPROM. A host can ask for the pins through a single 16-bit control word. Once it holds them, it drives the clock, the select and the serial data out directly. It samples the serial data in by reading the same word back.

Ownership is settled by a request/grant handshake with the internal engine. The engine reports `eng_busy`, and the block tells the engine through `host_owns` when the host holds the pins. While the host has no grant, the engine's own pin values go to the pins. The stored host bits wait in a shadow register until a grant arrives.

A host that forgets to let go is dealt with by an idle timer. If the host-driven pin bits stay unchanged for `IDLE_LIMIT` cycles, the block drops both request and grant, and the pins go back to the engine. The read-back word also carries two read-only fields taken from straps: an EEPROM-present flag and a 4-bit size code.

Top module: `spi_pin_arbiter`

## Requirements
- R1: After reset, the host shadow bits are clock 0, select 1 (inactive) and data-out 0. Request and grant are 0, so the pins carry the engine values and `host_owns` is 0.
- R2: A register write stores bit 0 as the host clock, bit 1 as the host select (active low) and bit 2 as the host data-out. These bits read back at the same positions in the cycle after the write.
- R3: Bit 6 is the host request, and it is read back in bit 6. The grant (read-only bit 7, and `host_owns`) rises one cycle after the request is seen high while `eng_busy` is 0. It stays low while `eng_busy` is 1.
- R4: Once the grant is set, it stays set while the request stays set, even if `eng_busy` rises.
- R5: Clearing the request drops the grant on the next cycle.
- R6: While the grant is set, `spi_sck`, `spi_cs_n` and `spi_mosi` follow the host shadow bits. While it is clear, they follow `eng_sck`, `eng_cs_n` and `eng_mosi`, and host writes do not reach the pins.
- R7: Bit 3 reads the `spi_miso` pin through a `SYNC_STAGES`-flop synchroniser. A level present at an edge appears in bit 3 after `SYNC_STAGES` edges.
- R8: Bit 8 reports `pres_strap`, and bits 14:11 report `size_strap` (code 7 = 16 KB part, code 8 = 32 KB part). Bits 3, 7, 8 and 11-14 ignore writes. All other bits read 0.
- R9: With the grant set and no change of the host pin bits, request and grant both clear after `IDLE_LIMIT` cycles counted from the grant edge.
- R10: A write that changes any of the clock, select or data-out bits restarts the idle count, so the grant then lasts `IDLE_LIMIT` cycles from that write. A write that leaves them unchanged does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word read-back |
| eng_busy | input | 1 | Internal engine is mid-transfer |
| eng_sck | input | 1 | Engine serial clock |
| eng_cs_n | input | 1 | Engine chip select, active low |
| eng_mosi | input | 1 | Engine serial data out |
| host_owns | output | 1 | Host holds the pins; engine must stay idle |
| pres_strap | input | 1 | EEPROM present strap |
| size_strap | input | 4 | EEPROM size code strap |
| spi_sck | output | 1 | Serial clock pin |
| spi_cs_n | output | 1 | Chip select pin, active low |
| spi_mosi | output | 1 | Serial data out pin |
| spi_miso | input | 1 | Serial data in pin |

## Verification
A wrong request or grant state shows up as a wrong bit 6 or 7 one cycle later. It also shows up on the pins, which switch to the wrong source in that same cycle. A faulty idle counter shows up only at the end of a window: the grant drops one cycle early or late, or it drops after a pin-changing write that should have restarted the count. For that reason the timeout is checked at both sides of the expected edge. A shadow-bit or synchroniser fault shows up in the read-back word within one cycle or `SYNC_STAGES` cycles.

// File: rtl/spi_arb_pkg.sv
package spi_arb_pkg;

  localparam int unsigned REG_W  = 16;
  localparam int unsigned SIZE_W = 4;

  // bit positions in the control word
  localparam int unsigned B_SCK  = 0;
  localparam int unsigned B_CS   = 1;
  localparam int unsigned B_MOSI = 2;
  localparam int unsigned B_MISO = 3;
  localparam int unsigned B_REQ  = 6;
  localparam int unsigned B_GNT  = 7;
  localparam int unsigned B_PRES = 8;
  localparam int unsigned B_SIZE = 11;

  typedef struct packed {
    logic mosi;
    logic cs_n;
    logic sck;
  } pins_t;

  localparam pins_t PINS_RESET = '{mosi: 1'b0, cs_n: 1'b1, sck: 1'b0};

  function automatic pins_t pick_host(logic [REG_W-1:0] w);
    pins_t p;
    p.sck  = w[B_SCK];
    p.cs_n = w[B_CS];
    p.mosi = w[B_MOSI];
    return p;
  endfunction

  function automatic logic pins_differ(pins_t a, pins_t b);
    return (a.sck != b.sck) || (a.cs_n != b.cs_n) || (a.mosi != b.mosi);
  endfunction

  function automatic logic [REG_W-1:0] pack_status(pins_t h, logic miso, logic req,
                                                   logic gnt, logic pres,
                                                   logic [SIZE_W-1:0] size);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_SCK]  = h.sck;
    w[B_CS]   = h.cs_n;
    w[B_MOSI] = h.mosi;
    w[B_MISO] = miso;
    w[B_REQ]  = req;
    w[B_GNT]  = gnt;
    w[B_PRES] = pres;
    w[B_SIZE +: SIZE_W] = size;
    return w;
  endfunction

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/arb_grant.sv
module arb_grant (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_req,
  input  logic expire,
  input  logic eng_busy,
  output logic req,
  output logic gnt
);
  logic req_d, gnt_d;

  always_comb begin
    if (expire) begin
      req_d = 1'b0;
      gnt_d = 1'b0;
    end else begin
      req_d = wr_en ? wr_req : req;
      // grant is taken from an idle engine and then kept while requested
      gnt_d = req && (gnt || !eng_busy);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0;
      gnt <= 1'b0;
    end else begin
      req <= req_d;
      gnt <= gnt_d;
    end
  end
endmodule

// File: rtl/arb_idle_timer.sv
module arb_idle_timer #(
  parameter int unsigned IDLE_LIMIT = 250_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic activity,
  output logic expire
);
  localparam int unsigned CNT_W = (IDLE_LIMIT > 2) ? $clog2(IDLE_LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_LIMIT - 1);

  logic [CNT_W-1:0] cnt;
  logic             at_last;

  assign at_last = (cnt == LAST);
  assign expire  = armed && !activity && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!armed || activity) cnt <= '0;
    else if (!at_last)          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/arb_pin_mux.sv
module arb_pin_mux
  import spi_arb_pkg::*;
(
  input  logic  sel_host,
  input  pins_t host,
  input  pins_t eng,
  output pins_t pins
);
  always_comb begin
    pins = sel_host ? host : eng;
  end
endmodule

// File: rtl/spi_pin_arbiter.sv
module spi_pin_arbiter
  import spi_arb_pkg::*;
#(
  parameter int unsigned IDLE_LIMIT  = 250_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             eng_busy,
  input  logic             eng_sck,
  input  logic             eng_cs_n,
  input  logic             eng_mosi,
  output logic             host_owns,
  input  logic             pres_strap,
  input  logic [SIZE_W-1:0] size_strap,
  output logic             spi_sck,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  pins_t host_q, host_wr, eng_pins, out_pins;
  logic  req_q, gnt_q, expire_evt, pin_activity, miso_s;
  logic  unused_wbits;

  assign unused_wbits = ^{reg_wdata[REG_W-1:B_REQ+1], reg_wdata[B_REQ-1:B_MOSI+1]};

  assign host_wr      = pick_host(reg_wdata);
  assign pin_activity = reg_wr && pins_differ(host_wr, host_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      host_q <= PINS_RESET;
    else if (reg_wr) host_q <= host_wr;
  end

  arb_idle_timer #(.IDLE_LIMIT(IDLE_LIMIT)) u_idle (
    .clk(clk), .rst_n(rst_n), .armed(gnt_q), .activity(pin_activity), .expire(expire_evt)
  );

  arb_grant u_grant (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_req(reg_wdata[B_REQ]),
    .expire(expire_evt), .eng_busy(eng_busy), .req(req_q), .gnt(gnt_q)
  );

  arb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(spi_miso), .q(miso_s)
  );

  assign eng_pins.sck  = eng_sck;
  assign eng_pins.cs_n = eng_cs_n;
  assign eng_pins.mosi = eng_mosi;

  arb_pin_mux u_mux (
    .sel_host(gnt_q), .host(host_q), .eng(eng_pins), .pins(out_pins)
  );

  assign spi_sck   = out_pins.sck;
  assign spi_cs_n  = out_pins.cs_n;
  assign spi_mosi  = out_pins.mosi;
  assign host_owns = gnt_q;
  assign reg_rdata = pack_status(host_q, miso_s, req_q, gnt_q, pres_strap, size_strap);
endmodule

// File: rtl/spi_pin_arbiter_chk.sv
module spi_pin_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic req_q,
  input logic gnt_q,
  input logic eng_busy,
  input logic pin_activity,
  input logic expire_evt
);
  // R3
  gnt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_q) |-> ($past(req_q) && !$past(eng_busy)));

  // R4
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q && req_q && !expire_evt) |=> gnt_q);

  // R5
  gnt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q |=> !gnt_q);

  // R9
  expire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> (!req_q && !gnt_q));

  // R10
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_activity |=> !expire_evt);
endmodule

bind spi_pin_arbiter spi_pin_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_q(req_q), .gnt_q(gnt_q), .eng_busy(eng_busy),
  .pin_activity(pin_activity), .expire_evt(expire_evt)
);

// File: tb/tb_spi_pin_arbiter.sv
module tb_spi_pin_arbiter;
  localparam int LIM = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic eng_busy = 1'b1, eng_sck = 1'b1, eng_cs_n = 1'b0, eng_mosi = 1'b1;
  logic host_owns;
  logic pres_strap = 1'b1;
  logic [3:0] size_strap = 4'd7;
  logic spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  int checks = 0, errors = 0, ncyc = 0;

  // bench model
  logic m_sck, m_cs, m_mosi, m_req, m_gnt, m_s1, m_s2;
  int   m_cnt;

  always #2 clk = ~clk;

  spi_pin_arbiter #(.IDLE_LIMIT(LIM), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_busy(eng_busy), .eng_sck(eng_sck), .eng_cs_n(eng_cs_n), .eng_mosi(eng_mosi),
    .host_owns(host_owns), .pres_strap(pres_strap), .size_strap(size_strap),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 50000) begin
      errors++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < 50000)", ncyc);
      summary();
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word();
    return {1'b0, size_strap, 2'b00, pres_strap, m_gnt, m_req, 2'b00, m_s2, m_mosi, m_cs, m_sck};
  endfunction

  task automatic compare_all();
    logic [2:0] ep;
    chk(reg_rdata[2:0] == {m_mosi, m_cs, m_sck}, "R2 host bits", {13'd0, reg_rdata[2:0]}, {13'd0, m_mosi, m_cs, m_sck});
    chk(reg_rdata[7:6] == {m_gnt, m_req} && host_owns == m_gnt, "R3 req/gnt",
        {14'd0, reg_rdata[7:6]}, {14'd0, m_gnt, m_req});
    chk(reg_rdata[3] == m_s2, "R7 miso", {15'd0, reg_rdata[3]}, {15'd0, m_s2});
    chk({reg_rdata[15:8], reg_rdata[5:4]} == {1'b0, size_strap, 2'b00, pres_strap, 2'b00}, "R8 ro fields",
        reg_rdata, exp_word());
    ep = m_gnt ? {m_mosi, m_cs, m_sck} : {eng_mosi, eng_cs_n, eng_sck};
    chk({spi_mosi, spi_cs_n, spi_sck} == ep, "R6 pins", {13'd0, spi_mosi, spi_cs_n, spi_sck}, {13'd0, ep});
  endtask

  // one clock: drive at negedge, model the edge, compare at the next negedge
  task automatic cyc(input logic wr, input logic [15:0] d);
    logic act, ex, n_req, n_gnt;
    reg_wr = wr;
    reg_wdata = d;
    @(posedge clk);
    act = wr && (d[2:0] != {m_mosi, m_cs, m_sck});
    ex = m_gnt && !act && (m_cnt == LIM - 1);
    n_gnt = ex ? 1'b0 : (m_req && (m_gnt || !eng_busy));
    n_req = ex ? 1'b0 : (wr ? d[6] : m_req);
    if (!m_gnt || act) m_cnt = 0;
    else if (m_cnt != LIM - 1) m_cnt = m_cnt + 1;
    m_req = n_req;
    m_gnt = n_gnt;
    if (wr) {m_mosi, m_cs, m_sck} = d[2:0];
    m_s2 = m_s1;
    m_s1 = spi_miso;
    @(negedge clk);
    reg_wr = 1'b0;
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'h0);
  endtask

  initial begin
    logic [31:0] r;
    r = $urandom(32'd2024);
    m_sck = 0; m_cs = 1; m_mosi = 0; m_req = 0; m_gnt = 0; m_s1 = 0; m_s2 = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(reg_rdata == 16'h3902 && !host_owns, "R1 reset word", reg_rdata, 16'h3902);
    chk({spi_mosi, spi_cs_n, spi_sck} == 3'b101, "R1 pins follow engine", {13'd0, spi_mosi, spi_cs_n, spi_sck}, 16'h5);

    // R3 / R6: request while engine busy: no grant, host bits stay off the pins
    cyc(1'b1, 16'h0045);
    idle(3);
    chk(!host_owns && reg_rdata[6], "R3 held off while busy", {15'd0, host_owns}, 16'h0);
    chk({spi_mosi, spi_cs_n, spi_sck} == 3'b101, "R6 host write blocked", {13'd0, spi_mosi, spi_cs_n, spi_sck}, 16'h5);

    // R3 grant one cycle after engine goes idle
    eng_busy = 1'b0;
    cyc(1'b0, 16'h0);
    chk(host_owns == 1'b1, "R3 grant after idle engine", {15'd0, host_owns}, 16'h1);
    chk({spi_mosi, spi_cs_n, spi_sck} == 3'b101, "R6 host bits on pins", {13'd0, spi_mosi, spi_cs_n, spi_sck}, 16'h5);

    // R4 grant held while engine busy again
    eng_busy = 1'b1;
    idle(4);
    chk(host_owns == 1'b1, "R4 grant kept", {15'd0, host_owns}, 16'h1);

    // R5 release
    cyc(1'b1, 16'h0002);
    chk(host_owns == 1'b1, "R5 grant one more cycle", {15'd0, host_owns}, 16'h1);
    cyc(1'b0, 16'h0);
    chk(host_owns == 1'b0, "R5 grant dropped", {15'd0, host_owns}, 16'h0);

    // R9 timeout from the grant edge
    eng_busy = 1'b0;
    cyc(1'b1, 16'h0042);
    cyc(1'b0, 16'h0);
    chk(host_owns == 1'b1, "R9 granted", {15'd0, host_owns}, 16'h1);
    idle(LIM - 1);
    chk(host_owns == 1'b1, "R9 still granted at LIM-1", {15'd0, host_owns}, 16'h1);
    idle(1);
    chk(host_owns == 1'b0 && !reg_rdata[6], "R9 expired at LIM", {14'd0, reg_rdata[7:6]}, 16'h0);

    // R10 unchanged write does not reload, changing write does
    cyc(1'b1, 16'h0042);
    cyc(1'b0, 16'h0);
    idle(5);
    cyc(1'b1, 16'h0042);
    idle(LIM - 7);
    chk(host_owns == 1'b1, "R10 before expiry", {15'd0, host_owns}, 16'h1);
    idle(1);
    chk(host_owns == 1'b0, "R10 same-value write no reload", {15'd0, host_owns}, 16'h0);
    cyc(1'b1, 16'h0042);
    cyc(1'b0, 16'h0);
    idle(8);
    cyc(1'b1, 16'h0043);
    idle(LIM - 1);
    chk(host_owns == 1'b1, "R10 reloaded grant", {15'd0, host_owns}, 16'h1);
    idle(1);
    chk(host_owns == 1'b0, "R10 expiry after reload", {15'd0, host_owns}, 16'h0);

    // R8 writes to read-only bits ignored, strap change visible
    cyc(1'b1, 16'hFFB8);
    chk(reg_rdata[15:8] == 8'h39 && reg_rdata[7] == 1'b0, "R8 ro bits ignore write", reg_rdata, exp_word());
    size_strap = 4'd8;
    pres_strap = 1'b0;
    cyc(1'b0, 16'h0);
    chk(reg_rdata[15:8] == 8'h40, "R8 size code 8 no present", {8'd0, reg_rdata[15:8]}, 16'h0040);

    // R7 miso sync latency
    spi_miso = 1'b1;
    cyc(1'b0, 16'h0);
    chk(reg_rdata[3] == 1'b0, "R7 not yet visible", {15'd0, reg_rdata[3]}, 16'h0);
    cyc(1'b0, 16'h0);
    chk(reg_rdata[3] == 1'b1, "R7 visible after 2 edges", {15'd0, reg_rdata[3]}, 16'h1);

    // random phase
    pres_strap = 1'b1;
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] rv;
      logic [15:0] d;
      rv = $urandom;
      eng_busy = (rv[3:0] < 4'd6);
      eng_sck = rv[4];
      eng_cs_n = rv[5];
      eng_mosi = rv[6];
      spi_miso = rv[7];
      d = rv[31:16];
      d[6] = (rv[11:8] < 4'd11);
      cyc(rv[14:12] == 3'd0, d);
    end

    summary();
  end
endmodule